// File: doc/BRIEF.md
# Statistical Feature Schedule Sequencer

This block is the timing brain of a statistics engine. The engine computes a set of time-domain features over a window of N = 2^LOG2N stored samples. Those features are the mean, rms, standard deviation, index of dispersion, kurtosis, skewness and a four-bin entropy. The engine has one single-cycle vectoring rotator, one subtractor, one multiplier and several accumulators. This block owns none of that arithmetic. Its job is to decide, on every clock, which unit works and which operands it sees:

- the sample-store read address;
- the rotator's coordinate mode;
- the x and y operand selects, including the feedback path that builds a sum of squares;
- the multiplier's operand select;
- the accumulator enables;
- the one-cycle strobes that tell the datapath to latch each finished feature.

A run is a fixed script of 3N+11 steps. The steps are numbered k = 0 .. 3N+10, where step k is the k-th cycle in which `busy` is high.

The sample store is read three times in full, because each later pass needs a result from the pass before it:

- **First pass.** Accumulates the sum for the mean and folds samples through the circular rotator for rms.
- **Second pass.** Subtracts the mean and folds the differences for the standard deviation.
- **Third pass.** Divides each difference by sigma in linear mode. The ratio is fed to the multiply and accumulate units for kurtosis and skewness. The dispersion division fits in between.
- **Entropy.** Four hyperbolic operations, one per bin, followed by four multiply-accumulate steps.

The store is assumed to return data one cycle after `rd_en`/`rd_addr`. Every datapath control therefore refers to the data present in that step. A result produced by the rotator or the multiplier in step k is assumed to be ready for capture in step k+1.

Top module: `feat_sched_ctrl`

## Requirements
- R1: After reset, and in every cycle with `busy` low, every output of the block is zero.
- R2: `start` is accepted only in a cycle with `busy` low; `busy` is then high for exactly 3N+11 cycles (steps 0..3N+10), and `start` raised while `busy` is high changes nothing.
- R3: Sample reads: `rd_en` is high and `rd_addr` equals k in steps 0..N-1, k-N-1 in steps N+1..2N, and k-2N-3 in steps 2N+3..3N+2; elsewhere both are zero.
- R4: Mean: `acc_clr` is high in step 0 only, `mean_acc_en` in steps 1..N, and `mean_vld` in step N+1.
- R5: Rms uses circular mode (`cordic_mode` = 01) in steps 2..N, with y select SAMPLE (1). The x select is PREV_SAMPLE (1) in step 2 and FEEDBACK (2) afterwards. `rms_vld` is high in step N+1.
- R6: Standard deviation uses circular mode in steps N+2..2N+1, with y select DIFF (2). The x select is ZERO (3) in step N+2 and FEEDBACK (2) afterwards. `sigma_vld` is high in step 2N+2.
- R7: Dispersion: step 2N+3 uses linear mode (00) with x select MEAN (4) and y select SIGMA (3). Step 2N+4 sets `mul_sel` to DISP (1), and `disp_vld` is high in step 2N+5.
- R8: Moments: steps 2N+4..3N+3 use linear mode with x select SIGMA (5) and y select DIFF (2). Steps 2N+5..3N+4 raise `moment_acc_en` with `mul_sel` = MOMENT (2). `moments_vld` is high in step 3N+5.
- R9: Entropy:
  - Steps 3N+4..3N+7 use hyperbolic mode (10) with x select ONE_PLUS_P (6), y select ONE_MINUS_P (4), and `cordic_bin` = k-3N-4.
  - Steps 3N+5..3N+8 raise `ent_mac_en` with `mul_sel` = ENT (3) and `mac_bin` = k-3N-5.
  - `entropy_vld` is high in step 3N+9.
- R10: `done` is high for one cycle, in step 3N+10, and `busy` is low in the next cycle. In every busy step without a rotator operation, `cordic_en` is low and `cordic_mode`, `x_sel`, `y_sel` and `cordic_bin` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a new run (taken only while idle) |
| busy | output | 1 | High during steps 0..3N+10 |
| rd_en | output | 1 | Sample-store read enable |
| rd_addr | output | LOG2N | Sample-store read address |
| cordic_en | output | 1 | Rotator performs an operation this step |
| cordic_mode | output | 2 | 00 linear, 01 circular, 10 hyperbolic |
| x_sel | output | 3 | Rotator x operand select |
| y_sel | output | 3 | Rotator y operand select |
| mean_acc_en | output | 1 | Add the current sample into the mean accumulator |
| moment_acc_en | output | 1 | Square/multiply and accumulate the current ratio |
| acc_clr | output | 1 | Clear all accumulators |
| mul_sel | output | 2 | Multiplier use: 0 none, 1 dispersion, 2 moment, 3 entropy |
| ent_mac_en | output | 1 | Entropy multiply-accumulate enable |
| cordic_bin | output | 2 | Bin whose probability drives the rotator |
| mac_bin | output | 2 | Bin whose probability feeds the entropy MAC |
| mean_vld | output | 1 | Latch mean |
| rms_vld | output | 1 | Latch rms |
| sigma_vld | output | 1 | Latch standard deviation |
| disp_vld | output | 1 | Latch index of dispersion |
| moments_vld | output | 1 | Latch kurtosis and skewness |
| entropy_vld | output | 1 | Latch entropy |
| done | output | 1 | Final step of a run |

## Verification
The assertions assume that `start` is the only stimulus. They also assume that a run is never cut short by reset mid-run. This is why the checker's step count can be compared against the fixed script length at each strobe. The bench respects this: it applies reset only before the first run. It pulses or holds `start` only at falling edges, including during a run and in the `done` cycle, where the requirements say the pulse must be ignored. Each of the 3N+11 steps of a small configuration (N = 8) is compared against expected values. Those values are derived from the step formulas over three runs.

// File: rtl/feat_sched_pkg.sv
package feat_sched_pkg;

  typedef enum logic [1:0] {
    CM_LIN  = 2'b00,
    CM_CIRC = 2'b01,
    CM_HYP  = 2'b10
  } cmode_e;

  typedef enum logic [2:0] {
    XS_NONE  = 3'd0,
    XS_PREV  = 3'd1,
    XS_FB    = 3'd2,
    XS_ZERO  = 3'd3,
    XS_MEAN  = 3'd4,
    XS_SIGMA = 3'd5,
    XS_OPP   = 3'd6
  } xsel_e;

  typedef enum logic [2:0] {
    YS_NONE   = 3'd0,
    YS_SAMPLE = 3'd1,
    YS_DIFF   = 3'd2,
    YS_SIGMA  = 3'd3,
    YS_OMP    = 3'd4
  } ysel_e;

  typedef enum logic [1:0] {
    MS_NONE = 2'd0,
    MS_DISP = 2'd1,
    MS_MOM  = 2'd2,
    MS_ENT  = 2'd3
  } msel_e;

  // index of each latch strobe inside the strobe vector
  localparam int unsigned STB_MEAN  = 0;
  localparam int unsigned STB_RMS   = 1;
  localparam int unsigned STB_SIGMA = 2;
  localparam int unsigned STB_DISP  = 3;
  localparam int unsigned STB_MOM   = 4;
  localparam int unsigned STB_ENT   = 5;
  localparam int unsigned STB_DONE  = 6;
  localparam int unsigned STB_NUM   = 7;

  typedef struct packed {
    logic               busy;
    logic               rd_en;
    logic               cordic_en;
    cmode_e             mode;
    xsel_e              xsel;
    ysel_e              ysel;
    logic               mean_acc;
    logic               mom_acc;
    logic               acc_clr;
    msel_e              msel;
    logic               ent_mac;
    logic [1:0]         cbin;
    logic [1:0]         mbin;
    logic [STB_NUM-1:0] stb;
  } ctrl_t;

  function automatic logic in_win(input logic [31:0] c, input logic [31:0] lo,
                                  input logic [31:0] hi);
    return (c >= lo) && (c <= hi);
  endfunction

endpackage

// File: rtl/feat_sched_timer.sv
module feat_sched_timer #(
  parameter int unsigned LAST = 43,
  parameter int unsigned CW   = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          run_d,
  output logic [CW-1:0] cnt_d
);

  logic          run_q;
  logic [CW-1:0] cnt_q;

  // next-state values are exported so the decoder can feed registered outputs
  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    if (!run_q) begin
      if (start) begin
        run_d = 1'b1;
        cnt_d = '0;
      end
    end else if (cnt_q == CW'(LAST)) begin
      run_d = 1'b0;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/feat_sched_decode.sv
module feat_sched_decode
  import feat_sched_pkg::*;
#(
  parameter int unsigned LOG2N = 8,
  parameter int unsigned CW    = 10
) (
  input  logic             run,
  input  logic [CW-1:0]    cnt,
  output ctrl_t            ctl,
  output logic [LOG2N-1:0] addr
);

  localparam int unsigned N = 1 << LOG2N;
  localparam int unsigned NPASS = 3;
  localparam int unsigned PASS_BASE [NPASS] = '{0, N + 1, 2 * N + 3};
  localparam int unsigned STB_AT [STB_NUM] =
    '{N + 1, N + 1, 2 * N + 2, 2 * N + 5, 3 * N + 5, 3 * N + 9, 3 * N + 10};

  // step boundaries of each rotator phase
  localparam int unsigned RMS_LO = 2;
  localparam int unsigned RMS_HI = N;
  localparam int unsigned SIG_LO = N + 2;
  localparam int unsigned SIG_HI = 2 * N + 1;
  localparam int unsigned DSP_AT = 2 * N + 3;
  localparam int unsigned MOM_LO = 2 * N + 4;
  localparam int unsigned MOM_HI = 3 * N + 3;
  localparam int unsigned HYP_LO = 3 * N + 4;
  localparam int unsigned HYP_HI = 3 * N + 7;
  localparam int unsigned MAC_LO = 3 * N + 5;
  localparam int unsigned MAC_HI = 3 * N + 8;

  logic [31:0]      c;
  logic [NPASS-1:0] hit;
  logic [LOG2N-1:0] part [NPASS];
  logic [STB_NUM-1:0] stb;

  assign c = 32'(cnt);

  genvar p;
  generate
    for (p = 0; p < NPASS; p++) begin : g_pass
      assign hit[p]  = run && in_win(c, PASS_BASE[p], PASS_BASE[p] + N - 1);
      assign part[p] = hit[p] ? LOG2N'(c - PASS_BASE[p]) : '0;
    end
  endgenerate

  genvar s;
  generate
    for (s = 0; s < STB_NUM; s++) begin : g_stb
      assign stb[s] = run && (c == STB_AT[s]);
    end
  endgenerate

  always_comb begin
    addr = '0;
    for (int i = 0; i < NPASS; i++) addr = addr | part[i];
  end

  always_comb begin
    ctl       = '0;
    ctl.busy  = run;
    ctl.rd_en = |hit;
    ctl.stb   = stb;
    if (run) begin
      ctl.acc_clr  = (c == 0);
      ctl.mean_acc = in_win(c, 1, N);
      ctl.mom_acc  = in_win(c, MOM_LO + 1, MOM_HI + 1);
      ctl.ent_mac  = in_win(c, MAC_LO, MAC_HI);

      if (in_win(c, RMS_LO, RMS_HI)) begin
        ctl.cordic_en = 1'b1;
        ctl.mode      = CM_CIRC;
        ctl.xsel      = (c == RMS_LO) ? XS_PREV : XS_FB;
        ctl.ysel      = YS_SAMPLE;
      end else if (in_win(c, SIG_LO, SIG_HI)) begin
        ctl.cordic_en = 1'b1;
        ctl.mode      = CM_CIRC;
        ctl.xsel      = (c == SIG_LO) ? XS_ZERO : XS_FB;
        ctl.ysel      = YS_DIFF;
      end else if (c == DSP_AT) begin
        ctl.cordic_en = 1'b1;
        ctl.mode      = CM_LIN;
        ctl.xsel      = XS_MEAN;
        ctl.ysel      = YS_SIGMA;
      end else if (in_win(c, MOM_LO, MOM_HI)) begin
        ctl.cordic_en = 1'b1;
        ctl.mode      = CM_LIN;
        ctl.xsel      = XS_SIGMA;
        ctl.ysel      = YS_DIFF;
      end else if (in_win(c, HYP_LO, HYP_HI)) begin
        ctl.cordic_en = 1'b1;
        ctl.mode      = CM_HYP;
        ctl.xsel      = XS_OPP;
        ctl.ysel      = YS_OMP;
        ctl.cbin      = 2'(c - HYP_LO);
      end

      if (c == DSP_AT + 1)  ctl.msel = MS_DISP;
      else if (ctl.mom_acc) ctl.msel = MS_MOM;
      else if (ctl.ent_mac) ctl.msel = MS_ENT;

      if (ctl.ent_mac) ctl.mbin = 2'(c - MAC_LO);
    end
  end

endmodule

// File: rtl/feat_sched_ctrl.sv
module feat_sched_ctrl
  import feat_sched_pkg::*;
#(
  parameter int unsigned LOG2N = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             busy,
  output logic             rd_en,
  output logic [LOG2N-1:0] rd_addr,
  output logic             cordic_en,
  output logic [1:0]       cordic_mode,
  output logic [2:0]       x_sel,
  output logic [2:0]       y_sel,
  output logic             mean_acc_en,
  output logic             moment_acc_en,
  output logic             acc_clr,
  output logic [1:0]       mul_sel,
  output logic             ent_mac_en,
  output logic [1:0]       cordic_bin,
  output logic [1:0]       mac_bin,
  output logic             mean_vld,
  output logic             rms_vld,
  output logic             sigma_vld,
  output logic             disp_vld,
  output logic             moments_vld,
  output logic             entropy_vld,
  output logic             done
);

  localparam int unsigned N    = 1 << LOG2N;
  localparam int unsigned LAST = 3 * N + 10;
  localparam int unsigned CW   = $clog2(LAST + 1);

  logic             run_d;
  logic [CW-1:0]    cnt_d;
  ctrl_t            ctl_d;
  ctrl_t            ctl_q;
  logic [LOG2N-1:0] addr_d;
  logic [LOG2N-1:0] addr_q;

  feat_sched_timer #(.LAST(LAST), .CW(CW)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .run_d (run_d),
    .cnt_d (cnt_d)
  );

  feat_sched_decode #(.LOG2N(LOG2N), .CW(CW)) u_decode (
    .run  (run_d),
    .cnt  (cnt_d),
    .ctl  (ctl_d),
    .addr (addr_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= '0;
      addr_q <= '0;
    end else begin
      ctl_q  <= ctl_d;
      addr_q <= addr_d;
    end
  end

  assign busy          = ctl_q.busy;
  assign rd_en         = ctl_q.rd_en;
  assign rd_addr       = addr_q;
  assign cordic_en     = ctl_q.cordic_en;
  assign cordic_mode   = ctl_q.mode;
  assign x_sel         = ctl_q.xsel;
  assign y_sel         = ctl_q.ysel;
  assign mean_acc_en   = ctl_q.mean_acc;
  assign moment_acc_en = ctl_q.mom_acc;
  assign acc_clr       = ctl_q.acc_clr;
  assign mul_sel       = ctl_q.msel;
  assign ent_mac_en    = ctl_q.ent_mac;
  assign cordic_bin    = ctl_q.cbin;
  assign mac_bin       = ctl_q.mbin;
  assign mean_vld      = ctl_q.stb[STB_MEAN];
  assign rms_vld       = ctl_q.stb[STB_RMS];
  assign sigma_vld     = ctl_q.stb[STB_SIGMA];
  assign disp_vld      = ctl_q.stb[STB_DISP];
  assign moments_vld   = ctl_q.stb[STB_MOM];
  assign entropy_vld   = ctl_q.stb[STB_ENT];
  assign done          = ctl_q.stb[STB_DONE];

endmodule

// File: rtl/feat_sched_chk.sv
module feat_sched_chk #(
  parameter int unsigned LOG2N = 8
) (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       busy,
  input logic       rd_en,
  input logic       cordic_en,
  input logic [1:0] cordic_mode,
  input logic [2:0] x_sel,
  input logic [2:0] y_sel,
  input logic [1:0] mul_sel,
  input logic       mean_vld,
  input logic       rms_vld,
  input logic       sigma_vld,
  input logic       disp_vld,
  input logic       moments_vld,
  input logic       entropy_vld,
  input logic       done
);

  localparam int unsigned N    = 1 << LOG2N;
  localparam int unsigned LAST = 3 * N + 10;

  // number of busy cycles already seen in the current run (= step index)
  logic [31:0] steps;
  always_ff @(posedge clk) begin
    if (rst || !busy) steps <= '0;
    else              steps <= steps + 1;
  end

  // R2
  busy_needs_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  // R2
  busy_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> busy);

  // R10
  done_ends_run_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);

  // R10
  done_step_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (busy && steps == LAST));

  // R4
  mean_step_chk: assert property (@(posedge clk) disable iff (rst)
    mean_vld |-> (steps == N + 1));

  // R5
  rms_pairs_mean_chk: assert property (@(posedge clk) disable iff (rst)
    rms_vld == mean_vld);

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rms_vld, sigma_vld, disp_vld, moments_vld, entropy_vld, done}));

  // R5
  feedback_after_op_chk: assert property (@(posedge clk) disable iff (rst)
    (cordic_en && x_sel == 3'd2) |-> ($past(cordic_en) && $past(cordic_mode) == cordic_mode));

  // R9
  hyp_operands_chk: assert property (@(posedge clk) disable iff (rst)
    (cordic_en && cordic_mode == 2'b10) |-> (x_sel == 3'd6 && y_sel == 3'd4));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!cordic_en && !rd_en && mul_sel == 2'd0));

endmodule

bind feat_sched_ctrl feat_sched_chk #(.LOG2N(LOG2N)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .busy        (busy),
  .rd_en       (rd_en),
  .cordic_en   (cordic_en),
  .cordic_mode (cordic_mode),
  .x_sel       (x_sel),
  .y_sel       (y_sel),
  .mul_sel     (mul_sel),
  .mean_vld    (mean_vld),
  .rms_vld     (rms_vld),
  .sigma_vld   (sigma_vld),
  .disp_vld    (disp_vld),
  .moments_vld (moments_vld),
  .entropy_vld (entropy_vld),
  .done        (done)
);

// File: tb/feat_sched_ctrl_tb.sv
`timescale 1ns/1ps
module feat_sched_ctrl_tb;

  localparam int LOG2N = 3;
  localparam int N     = 1 << LOG2N;
  localparam int LAST  = 3 * N + 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic busy, rd_en, cordic_en, mean_acc_en, moment_acc_en, acc_clr, ent_mac_en;
  logic [LOG2N-1:0] rd_addr;
  logic [1:0] cordic_mode, mul_sel, cordic_bin, mac_bin;
  logic [2:0] x_sel, y_sel;
  logic mean_vld, rms_vld, sigma_vld, disp_vld, moments_vld, entropy_vld, done;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  feat_sched_ctrl #(.LOG2N(LOG2N)) u_dut (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .rd_en(rd_en),
    .rd_addr(rd_addr), .cordic_en(cordic_en), .cordic_mode(cordic_mode),
    .x_sel(x_sel), .y_sel(y_sel), .mean_acc_en(mean_acc_en),
    .moment_acc_en(moment_acc_en), .acc_clr(acc_clr), .mul_sel(mul_sel),
    .ent_mac_en(ent_mac_en), .cordic_bin(cordic_bin), .mac_bin(mac_bin),
    .mean_vld(mean_vld), .rms_vld(rms_vld), .sigma_vld(sigma_vld),
    .disp_vld(disp_vld), .moments_vld(moments_vld), .entropy_vld(entropy_vld),
    .done(done)
  );

  task automatic chk(input string tag, input int k, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s step=%0d actual=%0d expected=%0d", tag, k, act, exp);
    end
  endtask

  function automatic bit win(input int k, input int lo, input int hi);
    return (k >= lo) && (k <= hi);
  endfunction

  // every output zero while idle
  task automatic check_idle(input string tag);
    int all;
    all = busy + rd_en + rd_addr + cordic_en + cordic_mode + x_sel + y_sel +
          mean_acc_en + moment_acc_en + acc_clr + mul_sel + ent_mac_en +
          cordic_bin + mac_bin + mean_vld + rms_vld + sigma_vld + disp_vld +
          moments_vld + entropy_vld + done;
    chk(tag, -1, all, 0);
  endtask

  task automatic check_step(input int k);
    int e_rd, e_addr, e_en, e_mode, e_x, e_y, e_mul, e_cbin, e_mbin;
    // R2: busy over the whole script
    chk("R2 busy", k, busy, 1);
    // R3: three read passes
    e_rd = 0; e_addr = 0;
    if (win(k, 0, N - 1))               begin e_rd = 1; e_addr = k; end
    else if (win(k, N + 1, 2 * N))      begin e_rd = 1; e_addr = k - N - 1; end
    else if (win(k, 2 * N + 3, 3 * N + 2)) begin e_rd = 1; e_addr = k - 2 * N - 3; end
    chk("R3 rd_en", k, rd_en, e_rd);
    chk("R3 rd_addr", k, rd_addr, e_addr);
    // R4: mean
    chk("R4 acc_clr", k, acc_clr, k == 0);
    chk("R4 mean_acc_en", k, mean_acc_en, win(k, 1, N));
    chk("R4 mean_vld", k, mean_vld, k == N + 1);
    // rotator operations R5..R10
    e_en = 0; e_mode = 0; e_x = 0; e_y = 0; e_cbin = 0;
    if (win(k, 2, N)) begin
      e_en = 1; e_mode = 1; e_y = 1; e_x = (k == 2) ? 1 : 2;
    end else if (win(k, N + 2, 2 * N + 1)) begin
      e_en = 1; e_mode = 1; e_y = 2; e_x = (k == N + 2) ? 3 : 2;
    end else if (k == 2 * N + 3) begin
      e_en = 1; e_mode = 0; e_x = 4; e_y = 3;
    end else if (win(k, 2 * N + 4, 3 * N + 3)) begin
      e_en = 1; e_mode = 0; e_x = 5; e_y = 2;
    end else if (win(k, 3 * N + 4, 3 * N + 7)) begin
      e_en = 1; e_mode = 2; e_x = 6; e_y = 4; e_cbin = k - 3 * N - 4;
    end
    chk("R5 R6 R7 R8 R9 R10 cordic_en", k, cordic_en, e_en);
    chk("R5 R6 R7 R8 R9 R10 cordic_mode", k, cordic_mode, e_mode);
    chk("R5 R6 R7 R8 R9 R10 x_sel", k, x_sel, e_x);
    chk("R5 R6 R7 R8 R9 R10 y_sel", k, y_sel, e_y);
    chk("R9 cordic_bin", k, cordic_bin, e_cbin);
    chk("R5 rms_vld", k, rms_vld, k == N + 1);
    chk("R6 sigma_vld", k, sigma_vld, k == 2 * N + 2);
    // R7 R8 R9: multiplier and accumulators
    e_mul = 0; e_mbin = 0;
    if (k == 2 * N + 4)                     e_mul = 1;
    else if (win(k, 2 * N + 5, 3 * N + 4)) e_mul = 2;
    else if (win(k, 3 * N + 5, 3 * N + 8)) begin e_mul = 3; e_mbin = k - 3 * N - 5; end
    chk("R7 R8 R9 mul_sel", k, mul_sel, e_mul);
    chk("R7 disp_vld", k, disp_vld, k == 2 * N + 5);
    chk("R8 moment_acc_en", k, moment_acc_en, win(k, 2 * N + 5, 3 * N + 4));
    chk("R8 moments_vld", k, moments_vld, k == 3 * N + 5);
    chk("R9 ent_mac_en", k, ent_mac_en, win(k, 3 * N + 5, 3 * N + 8));
    chk("R9 mac_bin", k, mac_bin, e_mbin);
    chk("R9 entropy_vld", k, entropy_vld, k == 3 * N + 9);
    chk("R10 done", k, done, k == LAST);
  endtask

  // one run; extra start pulses at step mid_k and/or in the done step
  task automatic run_once(input int mid_k, input bit start_at_done);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int k = 0; k <= LAST; k++) begin
      check_step(k);
      start = (k == mid_k) || (start_at_done && k == LAST);
      @(negedge clk);
    end
    start = 1'b0;
    // R10: run ends right after done; R2: start in done step ignored
    chk("R10 busy after done", LAST + 1, busy, 0);
    check_idle("R1 R2 idle after run");
    @(negedge clk);
    check_idle("R1 R2 still idle");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_idle("R1 during reset");
    rst = 1'b0;
    @(negedge clk);
    check_idle("R1 after reset");
    run_once(-1, 1'b0);
    run_once(5, 1'b1);
    run_once(2 * N + 3, 1'b0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule